// File: doc/BRIEF.md
# Bus Wait-State and Alignment Controller

This block sits on the system side of a 16-bit processor bus and decides, for each bus cycle, when the data acknowledge comes back. A free-running phase counter splits time into four-clock slots. When the address strobe is seen asserted, the controller reads the region decode and the current phase, and from them computes the total length of the cycle.

Main memory and the video shifter may only be reached on a slot boundary, so a request that arrives off-boundary is stretched until the next boundary. Program ROM and general I/O complete in the base four clocks wherever they start. The slow sound chip always gets exactly one extra clock. An odd number of waits is therefore legal. After a sound-chip cycle the bus runs at an odd phase until the next memory or video access pulls it back onto a boundary.

The length and start phase of the current cycle are presented as status outputs. The active-low acknowledge is driven in the final clock of the cycle and held until the strobe is released.

Top module: `bus_wait_ctrl`

## Requirements
- R1: During and right after synchronous reset, `dtack_n` is 1, `phase_o` is 0, `cyc_len_o` is 0 and `start_phase_o` is 0.
- R2: `phase_o` advances by one modulo 4 on every clock edge after reset, whatever the bus activity. The edge right after reset is released has phase 0.
- R3: A cycle whose region code is 3 (ROM) or 4 to 7 (other I/O) lasts 4 clocks at any start phase.
- R4: A cycle whose region code is 2 (sound chip) lasts 5 clocks at any start phase.
- R5: A cycle whose region code is 0 (main RAM) or 1 (video shifter) that starts at phase p lasts 4 + ((4 − p) mod 4) clocks. Start phase 0 gives 4 clocks, and start phase 1 gives 7 clocks.
- R6: The start edge is the first edge at which `as_n` is sampled low with the controller idle. `dtack_n` goes low L−1 edges after the start edge, where L is the cycle length, and it stays low while `as_n` is held low.
- R7: `dtack_n` returns to 1 at the first edge at which `as_n` is sampled high after acknowledge. A new cycle starts only after that.
- R8: From the start edge onward, `cyc_len_o` shows the cycle length L and `start_phase_o` shows the phase at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| region | input | 3 | Region decode of the current address |
| dtack_n | output | 1 | Data acknowledge, active low, registered |
| phase_o | output | 2 | Free-running slot phase |
| start_phase_o | output | 2 | Phase at which the current cycle started |
| cyc_len_o | output | 4 | Total clock count of the current cycle |

## Verification
Memory and video cycles are started deliberately at each of the four phases. These runs separate a correct alignment rule from one that adds only the raw phase, and from one that skips the pairing case at phase 0. A directed run of sound, memory, sound with no idle gap shows that the odd phase carries forward and is then realigned. Random mixes of region, idle gap and acknowledge hold time, from a fixed seed, check length, start phase, acknowledge timing and release against counts computed in the bench.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  // Region decode codes; unlisted codes behave as general I/O
  localparam logic [2:0] RG_RAM   = 3'd0;
  localparam logic [2:0] RG_VIDEO = 3'd1;
  localparam logic [2:0] RG_SOUND = 3'd2;
  localparam logic [2:0] RG_ROM   = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACKED} seq_state_e;

  function automatic logic needs_slot(input logic [2:0] rg);
    return (rg == RG_RAM) || (rg == RG_VIDEO);
  endfunction

  function automatic logic is_slow(input logic [2:0] rg);
    return rg == RG_SOUND;
  endfunction
endpackage

// File: rtl/bwc_phase.sv
module bwc_phase #(
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + PHASE_W'(1);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == $past(phase) + PHASE_W'(1)); // R2
endmodule

// File: rtl/bwc_len_calc.sv
module bwc_len_calc
  import bwc_pkg::*;
#(
  parameter int PHASE_W  = 2,
  parameter int LEN_W    = 4,
  parameter int BASE_CYC = 4,
  parameter int SND_WAIT = 1
) (
  input  logic [2:0]         region,
  input  logic [PHASE_W-1:0] phase,
  output logic               slot_req,
  output logic [LEN_W-1:0]   len
);
  logic [PHASE_W-1:0] gap;
  logic [LEN_W-1:0]   align_add;
  logic [LEN_W-1:0]   slow_add;

  always_comb begin
    // distance to the next slot boundary, zero when already on it
    gap       = PHASE_W'(0) - phase;
    slot_req  = needs_slot(region);
    align_add = slot_req ? LEN_W'(gap) : '0;
    slow_add  = is_slow(region) ? LEN_W'(SND_WAIT) : '0;
    len       = LEN_W'(BASE_CYC) + align_add + slow_add;
  end

  AST_LEN_FLOOR: assert final (len >= LEN_W'(BASE_CYC)); // R3
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
#(
  parameter int PHASE_W = 2,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               as_n,
  input  logic               slot_req,
  input  logic [LEN_W-1:0]   len_in,
  input  logic [PHASE_W-1:0] phase,
  output logic               start,
  output logic               dtack_n,
  output logic [PHASE_W-1:0] start_phase,
  output logic [LEN_W-1:0]   cyc_len
);
  seq_state_e       state;
  logic [LEN_W-1:0] cnt;
  logic             slot_q;
  logic             last;

  assign start = (state == S_IDLE) && !as_n;
  assign last  = (state == S_BUSY) && (cnt + LEN_W'(1) == cyc_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      slot_q      <= 1'b0;
      dtack_n     <= 1'b1;
      start_phase <= '0;
      cyc_len     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state       <= S_BUSY;
          cnt         <= LEN_W'(1);
          slot_q      <= slot_req;
          start_phase <= phase;
          cyc_len     <= len_in;
        end
        S_BUSY: if (last) begin
          dtack_n <= 1'b0;
          state   <= S_ACKED;
        end else begin
          cnt <= cnt + LEN_W'(1);
        end
        S_ACKED: if (as_n) begin
          dtack_n <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SLOT_END: assert property (@(posedge clk) disable iff (rst)
    (last && slot_q) |-> phase == '1); // R5
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && !as_n) |=> !dtack_n); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && as_n) |=> dtack_n); // R7
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> !$past(as_n)); // R6
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int PHASE_W  = 2,
  parameter int LEN_W    = 4,
  parameter int BASE_CYC = 4,
  parameter int SND_WAIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               as_n,
  input  logic [2:0]         region,
  output logic               dtack_n,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] start_phase_o,
  output logic [LEN_W-1:0]   cyc_len_o
);
  logic             slot_req;
  logic [LEN_W-1:0] len_calc;
  logic             start;

  bwc_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .phase(phase_o)
  );

  bwc_len_calc #(
    .PHASE_W(PHASE_W), .LEN_W(LEN_W), .BASE_CYC(BASE_CYC), .SND_WAIT(SND_WAIT)
  ) u_len (
    .region(region), .phase(phase_o), .slot_req(slot_req), .len(len_calc)
  );

  bwc_seq #(.PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .as_n(as_n), .slot_req(slot_req),
    .len_in(len_calc), .phase(phase_o), .start(start), .dtack_n(dtack_n),
    .start_phase(start_phase_o), .cyc_len(cyc_len_o)
  );

  AST_SOUND_LEN: assert property (@(posedge clk) disable iff (rst)
    (start && region == RG_SOUND) |=> cyc_len_o == LEN_W'(BASE_CYC + SND_WAIT)); // R4
  AST_ROM_LEN: assert property (@(posedge clk) disable iff (rst)
    (start && region == RG_ROM) |=> cyc_len_o == LEN_W'(BASE_CYC)); // R3
  AST_START_PHASE: assert property (@(posedge clk) disable iff (rst)
    start |=> start_phase_o == $past(phase_o)); // R8
endmodule

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       as_n = 1'b1;
  logic [2:0] region = 3'd0;
  logic       dtack_n;
  logic [1:0] phase_o;
  logic [1:0] start_phase_o;
  logic [3:0] cyc_len_o;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  bus_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .as_n(as_n), .region(region), .dtack_n(dtack_n),
    .phase_o(phase_o), .start_phase_o(start_phase_o), .cyc_len_o(cyc_len_o)
  );

  function automatic int exp_len(input logic [2:0] rg, input int p);
    if (rg == 3'd0 || rg == 3'd1) return 4 + ((4 - p) % 4);
    if (rg == 3'd2) return 5;
    return 4;
  endfunction

  function automatic string tag_of(input logic [2:0] rg);
    if (rg == 3'd0 || rg == 3'd1) return "R5";
    if (rg == 3'd2) return "R4";
    return "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Caller stands at a negedge; returns at the negedge after release
  task automatic access(input logic [2:0] rg, input int hold);
    int p, l, k;
    p = ecount % 4;
    l = exp_len(rg, p);
    as_n = 1'b0;
    region = rg;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (dtack_n && k < 20);
    check("R6 ack delay", k, l);
    check(tag_of(rg), int'(cyc_len_o), l);
    check("R8 start phase", int'(start_phase_o), p);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6 ack held", int'(dtack_n), 0);
    end
    as_n = 1'b1;
    region = 3'($urandom_range(0, 7));
    @(negedge clk);
    check("R7 release", int'(dtack_n), 1);
  endtask

  task automatic wait_phase(input int target);
    while (ecount % 4 != target) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 dtack", int'(dtack_n), 1);
    check("R1 len", int'(cyc_len_o), 0);
    check("R1 sphase", int'(start_phase_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 phase after first edge", int'(phase_o), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 phase", int'(phase_o), ecount % 4);
    end
    // memory and video at every phase, ROM/IO/sound too
    for (int p = 0; p < 4; p++) begin
      for (int rg = 0; rg < 8; rg++) begin
        wait_phase(p);
        access(3'(rg), 0);
      end
    end
    // odd phase carry then realignment, no idle gap
    wait_phase(0);
    access(3'd2, 0);
    access(3'd0, 0);
    access(3'd2, 0);
    access(3'd3, 0);
    access(3'd1, 1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      int gap;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) @(negedge clk);
      check("R2 phase", int'(phase_o), ecount % 4);
      access(3'($urandom_range(0, 7)), $urandom_range(0, 3));
    end
    done = 1;
    summary();
  end
endmodule